// File: doc/BRIEF.md
# LCD Window Flush Sequencer

This block turns a request to refresh a rectangle of a small LCD panel into the byte stream that the panel's command/data link expects. The panel has its own frame memory. The block first sends a column window and a row window. Each window is a command byte followed by four coordinate bytes. It then sends the memory-write command and, after it, every pixel of the rectangle as two bytes. Each byte carries a flag that marks it as command (0) or data (1). Fixed panel offsets are added to the coordinates before they are encoded. This lets a panel whose visible area does not start at the controller's origin be addressed by plain screen coordinates.

A request is a single-cycle strobe, sampled when the block is idle, with the rectangle, the offsets and two option bits. Pixels come in as RGB565 words on a valid/ready stream. Bytes leave on a second valid/ready stream. A byte stays on the output until the downstream link accepts it. A pixel word is taken from the source only in the cycle its first byte is accepted downstream, so `pix_ready` follows `out_ready` in the same cycle. A source that raises `pix_valid` must hold it and its data until it is accepted. The blank option fills the whole panel with zero pixels and consumes no input pixels.

Top module: `lcd_window_flush`

## Requirements
- R1: After reset, `busy`, `out_valid` and `pix_ready` are all 0.
- R2: Command bytes (`out_dc`=0) are 0x2A (column window), then 0x2B (row window), then 0x2C (memory write), sent in that order for every request.
- R3: Each window command is followed by four bytes with `out_dc`=1: start[15:8], start[7:0], end[15:8], end[7:0]. The ends are inclusive.
- R4: `left_off` is added to both column coordinates and `top_off` to both row coordinates, modulo 2^16, before encoding.
- R5: The memory-write command is followed by exactly (x_end-x_start+1)*(y_end-y_start+1) pixels, taken from the raw coordinates, with x_end ≥ x_start and y_end ≥ y_start. No byte follows them.
- R6: Each pixel is sent as two data bytes. With `req_swap`=0 the order is pix[15:8] then pix[7:0]. With `req_swap`=1 the two bytes are exchanged.
- R7: With `req_blank`=1 the windows are 0..PANEL_W-1 and 0..PANEL_H-1, each plus the offset. The payload is PANEL_W*PANEL_H*2 zero bytes, and `pix_ready` stays 0.
- R8: `busy` rises in the cycle after an accepted request and falls in the cycle after the last payload byte is accepted. A request seen while `busy` is 1 has no effect. `out_valid` is 0 while idle.
- R9: While `out_valid`=1 and `out_ready`=0, the next cycle shows the same `out_valid`, `out_data` and `out_dc`.
- R10: A pixel word is consumed (`pix_valid` and `pix_ready` both 1) only in a cycle where its first data byte is being accepted downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_blank | input | 1 | Fill the whole panel with zeros |
| req_swap | input | 1 | Send the low pixel byte first |
| x_start | input | CW | First column of the rectangle |
| x_end | input | CW | Last column (inclusive) |
| y_start | input | CW | First row of the rectangle |
| y_end | input | CW | Last row (inclusive) |
| left_off | input | CW | Column offset of the panel |
| top_off | input | CW | Row offset of the panel |
| busy | output | 1 | A request is in progress |
| pix_valid | input | 1 | Pixel source has a word |
| pix_ready | output | 1 | Pixel word is taken this cycle |
| pix_data | input | 16 | RGB565 pixel word |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_dc | output | 1 | 0 = command byte, 1 = data byte |

## Verification
The hardest condition to reach is a stall in the middle of a pixel. It happens when the downstream link pauses between the two bytes of a word while the source already offers the next word, or when the source has a gap just as the link becomes ready. The bench sets both conditions up by driving `out_ready` and `pix_valid` from independent pseudo-random patterns during long payloads, with byte swapping both on and off. Offset wrap-around is forced with coordinates at the top of the 16-bit range. Stray requests are injected during a transfer and must leave the stream untouched.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_PIX  = 2'd2
  } phase_t;

  localparam logic [7:0] OP_COL   = 8'h2A;
  localparam logic [7:0] OP_ROW   = 8'h2B;
  localparam logic [7:0] OP_MEMWR = 8'h2C;
  localparam int HDR_BYTES = 11;
  localparam int HDR_IW    = 4;
endpackage

// File: rtl/lwf_window.sv
module lwf_window #(
  parameter int CW      = 16,
  parameter int PANEL_W = 32,
  parameter int PANEL_H = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              blank,
  input  logic [CW-1:0]     x_start,
  input  logic [CW-1:0]     x_end,
  input  logic [CW-1:0]     y_start,
  input  logic [CW-1:0]     y_end,
  input  logic [CW-1:0]     left_off,
  input  logic [CW-1:0]     top_off,
  output logic [CW-1:0]     col_s,
  output logic [CW-1:0]     col_e,
  output logic [CW-1:0]     row_s,
  output logic [CW-1:0]     row_e,
  output logic [2*CW+1:0]   area
);
  localparam int AW = 2*CW + 2;

  logic [CW-1:0] bx_s, bx_e, by_s, by_e;
  logic [CW:0]   wdt, hgt;

  // blank covers the full panel; offsets still apply
  always_comb begin
    bx_s = blank ? '0 : x_start;
    bx_e = blank ? CW'(PANEL_W - 1) : x_end;
    by_s = blank ? '0 : y_start;
    by_e = blank ? CW'(PANEL_H - 1) : y_end;
    wdt  = {1'b0, bx_e} - {1'b0, bx_s} + (CW+1)'(1);
    hgt  = {1'b0, by_e} - {1'b0, by_s} + (CW+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_s <= '0;
      col_e <= '0;
      row_s <= '0;
      row_e <= '0;
      area  <= '0;
    end else if (load) begin
      col_s <= bx_s + left_off;
      col_e <= bx_e + left_off;
      row_s <= by_s + top_off;
      row_e <= by_e + top_off;
      area  <= AW'(wdt) * AW'(hgt);
    end
  end
endmodule

// File: rtl/lwf_header.sv
module lwf_header
  import lwf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [HDR_IW-1:0] idx,
  input  logic [CW-1:0]     col_s,
  input  logic [CW-1:0]     col_e,
  input  logic [CW-1:0]     row_s,
  input  logic [CW-1:0]     row_e,
  output logic [7:0]        hbyte,
  output logic              hdc
);
  logic [15:0] cs, ce, rs, re;

  assign cs = 16'(col_s);
  assign ce = 16'(col_e);
  assign rs = 16'(row_s);
  assign re = 16'(row_e);

  always_comb begin
    hdc   = 1'b1;
    hbyte = 8'h00;
    case (idx)
      4'd0:  begin hbyte = OP_COL;   hdc = 1'b0; end
      4'd1:  hbyte = cs[15:8];
      4'd2:  hbyte = cs[7:0];
      4'd3:  hbyte = ce[15:8];
      4'd4:  hbyte = ce[7:0];
      4'd5:  begin hbyte = OP_ROW;   hdc = 1'b0; end
      4'd6:  hbyte = rs[15:8];
      4'd7:  hbyte = rs[7:0];
      4'd8:  hbyte = re[15:8];
      4'd9:  hbyte = re[7:0];
      4'd10: begin hbyte = OP_MEMWR; hdc = 1'b0; end
      default: hbyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/lwf_pixel_split.sv
module lwf_pixel_split (
  input  logic [15:0] pix_in,
  input  logic [15:0] held,
  input  logic        second,
  input  logic        swap,
  input  logic        zero,
  output logic [7:0]  pbyte
);
  always_comb begin
    if (second)
      pbyte = swap ? held[15:8] : held[7:0];
    else if (zero)
      pbyte = 8'h00;
    else
      pbyte = swap ? pix_in[7:0] : pix_in[15:8];
  end
endmodule

// File: rtl/lcd_window_flush.sv
module lcd_window_flush
  import lwf_pkg::*;
#(
  parameter int CW      = 16,
  parameter int PANEL_W = 32,
  parameter int PANEL_H = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_blank,
  input  logic          req_swap,
  input  logic [CW-1:0] x_start,
  input  logic [CW-1:0] x_end,
  input  logic [CW-1:0] y_start,
  input  logic [CW-1:0] y_end,
  input  logic [CW-1:0] left_off,
  input  logic [CW-1:0] top_off,
  output logic          busy,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [15:0]   pix_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_dc
);
  localparam int AW = 2*CW + 2;

  phase_t            phase;
  logic [HDR_IW-1:0] hidx;
  logic [AW-1:0]     pcnt;
  logic              half;
  logic [15:0]       hold;
  logic              blank_q, swap_q;

  logic [CW-1:0]     col_s, col_e, row_s, row_e;
  logic [AW-1:0]     area;
  logic [7:0]        hbyte, pbyte;
  logic              hdc;
  logic              accept, fire, last_hdr, last_pix;

  assign accept   = (phase == PH_IDLE) && req_valid;
  assign fire     = out_valid && out_ready;
  assign last_hdr = (hidx == HDR_IW'(HDR_BYTES - 1));
  assign last_pix = (pcnt == area - AW'(1));
  assign busy     = (phase != PH_IDLE);

  lwf_window #(.CW(CW), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) u_win (
    .clk(clk), .rst_n(rst_n), .load(accept), .blank(req_blank),
    .x_start(x_start), .x_end(x_end), .y_start(y_start), .y_end(y_end),
    .left_off(left_off), .top_off(top_off),
    .col_s(col_s), .col_e(col_e), .row_s(row_s), .row_e(row_e), .area(area)
  );

  lwf_header #(.CW(CW)) u_hdr (
    .idx(hidx), .col_s(col_s), .col_e(col_e), .row_s(row_s), .row_e(row_e),
    .hbyte(hbyte), .hdc(hdc)
  );

  lwf_pixel_split u_split (
    .pix_in(pix_data), .held(hold), .second(half), .swap(swap_q),
    .zero(blank_q), .pbyte(pbyte)
  );

  // output mux: header bytes, then pixel bytes
  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_dc    = 1'b1;
    pix_ready = 1'b0;
    case (phase)
      PH_HDR: begin
        out_valid = 1'b1;
        out_data  = hbyte;
        out_dc    = hdc;
      end
      PH_PIX: begin
        out_valid = half || blank_q || pix_valid;
        out_data  = pbyte;
        pix_ready = !half && !blank_q && out_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      hidx    <= '0;
      pcnt    <= '0;
      half    <= 1'b0;
      hold    <= '0;
      blank_q <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_HDR;
          hidx    <= '0;
          blank_q <= req_blank;
          swap_q  <= req_swap;
        end
        PH_HDR: if (fire) begin
          if (last_hdr) begin
            phase <= PH_PIX;
            pcnt  <= '0;
            half  <= 1'b0;
          end else begin
            hidx <= hidx + HDR_IW'(1);
          end
        end
        PH_PIX: if (fire) begin
          if (!half) begin
            hold <= blank_q ? 16'h0000 : pix_data;
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            if (last_pix) phase <= PH_IDLE;
            else          pcnt  <= pcnt + AW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lwf_checker.sv
module lwf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       pix_valid,
  input logic       pix_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_dc
);
  p_cmd_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dc) |-> (out_data == 8'h2A || out_data == 8'h2B || out_data == 8'h2C))
    else $error("p_cmd_code_r2");

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy)
    else $error("p_accept_r8");

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !pix_ready))
    else $error("p_idle_quiet_r8");

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready && out_dc))
    else $error("p_busy_end_r8");

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dc)))
    else $error("p_hold_r9");

  p_pix_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |-> (out_valid && out_ready && out_dc))
    else $error("p_pix_take_r10");
endmodule

bind lcd_window_flush lwf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_dc(out_dc)
);

// File: tb/lcd_window_flush_test.sv
`timescale 1ns/1ps
module lcd_window_flush_test;
  localparam int PW = 32;
  localparam int PH = 16;

  typedef struct packed {
    logic [7:0] d;
    logic       dc;
    logic [3:0] rq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_blank = 1'b0, req_swap = 1'b0;
  logic [15:0] x_start = '0, x_end = '0, y_start = '0, y_end = '0;
  logic [15:0] left_off = '0, top_off = '0;
  logic        busy;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [15:0] pix_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_dc;

  always #2.5 clk = ~clk;

  lcd_window_flush #(.CW(16), .PANEL_W(PW), .PANEL_H(PH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blank(req_blank),
    .req_swap(req_swap), .x_start(x_start), .x_end(x_end), .y_start(y_start),
    .y_end(y_end), .left_off(left_off), .top_off(top_off), .busy(busy),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_dc(out_dc)
  );

  int          n_chk = 0, n_err = 0, cyc = 0;
  bit          timed_out = 0;
  exp_t        exp_q[$];
  logic [15:0] src_q[$];
  logic [31:0] lcg = 32'h1234_5678;

  // test controls
  bit          req_pending = 0, stray_en = 0, stall_mode = 0, gap_mode = 0, blank_src = 0;
  logic [15:0] p_xs, p_xe, p_ys, p_ye, p_lo, p_to;
  bit          p_blank, p_swap;
  int          addr_tag = 3, pix_tag = 6;

  // model state
  bit          exp_busy = 0, pix_hs_prev = 0, prev_stall = 0;
  logic [7:0]  prev_d;
  logic        prev_dc;

  function automatic int rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[23:16]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic push_b(input logic [7:0] d, input logic dc, input int rq);
    exp_t e;
    e.d = d; e.dc = dc; e.rq = rq[3:0];
    exp_q.push_back(e);
  endtask

  task automatic build();
    logic [15:0] cs, ce, rs, re, px;
    int w, h;
    if (p_blank) begin
      cs = p_lo; ce = p_lo + 16'(PW - 1); rs = p_to; re = p_to + 16'(PH - 1);
      w = PW; h = PH;
    end else begin
      cs = p_xs + p_lo; ce = p_xe + p_lo; rs = p_ys + p_to; re = p_ye + p_to;
      w = int'(p_xe - p_xs) + 1; h = int'(p_ye - p_ys) + 1;
    end
    // R2 command codes, R3/R4 window parameters
    push_b(8'h2A, 1'b0, 2);
    push_b(cs[15:8], 1'b1, addr_tag); push_b(cs[7:0], 1'b1, addr_tag);
    push_b(ce[15:8], 1'b1, addr_tag); push_b(ce[7:0], 1'b1, addr_tag);
    push_b(8'h2B, 1'b0, 2);
    push_b(rs[15:8], 1'b1, addr_tag); push_b(rs[7:0], 1'b1, addr_tag);
    push_b(re[15:8], 1'b1, addr_tag); push_b(re[7:0], 1'b1, addr_tag);
    push_b(8'h2C, 1'b0, 2);
    for (int i = 0; i < w*h; i++) begin
      if (p_blank) begin
        push_b(8'h00, 1'b1, 7); push_b(8'h00, 1'b1, 7);   // R7 zero payload
      end else begin
        px = 16'(i * 16'h1357 + 16'h0A5C);
        src_q.push_back(px);
        if (p_swap) begin push_b(px[7:0], 1'b1, pix_tag); push_b(px[15:8], 1'b1, pix_tag); end
        else        begin push_b(px[15:8], 1'b1, pix_tag); push_b(px[7:0], 1'b1, pix_tag); end
      end
    end
  endtask

  task automatic step();
    exp_t e;
    bit   nb;
    @(negedge clk);
    cyc++;
    if (cyc > 100000) timed_out = 1;
    // pixel source
    if (pix_hs_prev) begin
      if (src_q.size() > 0) void'(src_q.pop_front());
      pix_valid = 1'b0;
    end
    if (blank_src) begin
      pix_valid = 1'b1; pix_data = 16'hFFFF;
    end else if (!pix_valid && src_q.size() > 0 && (!gap_mode || (rnd() % 3) != 0)) begin
      pix_valid = 1'b1; pix_data = src_q[0];
    end else if (src_q.size() == 0) begin
      pix_valid = 1'b0;
    end
    out_ready = stall_mode ? ((rnd() % 4) != 0) : 1'b1;
    // requests
    req_valid = 1'b0;
    if (req_pending && !exp_busy) begin
      req_valid = 1'b1; req_blank = p_blank; req_swap = p_swap;
      x_start = p_xs; x_end = p_xe; y_start = p_ys; y_end = p_ye;
      left_off = p_lo; top_off = p_to;
    end else if (stray_en && exp_busy && (rnd() % 5) == 0) begin
      // R8: stray request while busy must change nothing
      req_valid = 1'b1; req_blank = 1'b1; req_swap = ~p_swap;
      x_start = 16'h0033; x_end = 16'h0044; y_start = 16'h0001; y_end = 16'h0009;
      left_off = 16'h0100; top_off = 16'h0200;
    end
    #1;
    chk(busy == exp_busy, "R8 busy", busy, exp_busy);
    if (!exp_busy) chk(!out_valid, "R8 idle out_valid", out_valid, 0);
    if (blank_src && exp_busy) chk(!pix_ready, "R7 pix_ready in blank", pix_ready, 0);
    if (prev_stall)
      chk(out_valid && out_data == prev_d && out_dc == prev_dc, "R9 hold",
          {out_valid, out_dc, out_data}, {1'b1, prev_dc, prev_d});
    prev_stall  = out_valid && !out_ready;
    prev_d      = out_data;
    prev_dc     = out_dc;
    pix_hs_prev = pix_valid && pix_ready;
    if (pix_hs_prev) chk(out_valid && out_ready && out_dc, "R10 pixel take", {out_valid, out_ready, out_dc}, 3'b111);
    nb = exp_busy;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 extra byte", {out_dc, out_data}, 0);
      end else begin
        e = exp_q.pop_front();
        chk({out_dc, out_data} == {e.dc, e.d}, $sformatf("R%0d byte", e.rq), {out_dc, out_data}, {e.dc, e.d});
        if (exp_q.size() == 0) nb = 1'b0;
      end
    end
    if (req_valid && !exp_busy) begin
      build();
      nb = 1'b1;
      req_pending = 0;
    end
    exp_busy = nb;
  endtask

  task automatic run_req(input logic [15:0] xs, xe, ys, ye, lo, to, input bit bl, sw);
    p_xs = xs; p_xe = xe; p_ys = ys; p_ye = ye; p_lo = lo; p_to = to;
    p_blank = bl; p_swap = sw; req_pending = 1;
    blank_src = bl;
    step();
    while ((req_pending || exp_busy || exp_q.size() != 0) && !timed_out) step();
    blank_src = 0;
    pix_valid = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!busy, "R1 busy", busy, 0);
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!pix_ready, "R1 pix_ready", pix_ready, 0);

    // R2/R3/R5: 3x2 rectangle, no offsets, free-running link
    addr_tag = 3; pix_tag = 5;
    run_req(16'd2, 16'd4, 16'd1, 16'd2, 16'd0, 16'd0, 0, 0);

    // R4/R6: offsets carry into high byte, swapped pixels, back-pressure
    addr_tag = 4; pix_tag = 6; stall_mode = 1; gap_mode = 1;
    run_req(16'h00FE, 16'h0101, 16'd3, 16'd5, 16'd2, 16'h0120, 0, 1);

    // R5/R8: single pixel with stray requests during the transfer
    addr_tag = 3; pix_tag = 5; stray_en = 1;
    run_req(16'd5, 16'd5, 16'd7, 16'd7, 16'd0, 16'd0, 0, 0);

    // R6/R9/R10: longer payload, unswapped, stalls and source gaps, strays
    pix_tag = 6;
    run_req(16'd0, 16'd9, 16'd0, 16'd4, 16'd1, 16'd1, 0, 0);

    // R7: blank fill with offsets under back-pressure
    stray_en = 0;
    addr_tag = 7;
    run_req(16'd0, 16'd0, 16'd0, 16'd0, 16'd1, 16'd3, 1, 0);

    // R4: offset wraps past the top of the coordinate range
    addr_tag = 4; pix_tag = 6;
    run_req(16'hFFFE, 16'hFFFF, 16'd0, 16'd0, 16'd1, 16'd0, 0, 1);

    if (timed_out) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule